// File: doc/BRIEF.md
# Leveled Interrupt Priority Arbiter

This block decides, on the processor side, whether a pending device interrupt is taken. Seven request lines, one per level from 1 to 7, are reduced by a priority encoder to a single level number. At each instruction boundary that level is compared with a current-priority register. A level above the current priority is accepted. Level 7 is non-maskable and is always accepted. When a request is accepted, the block emits a one-cycle take pulse with the accepted level, pushes the old priority onto a small internal save stack and raises the current priority to the accepted level. A return pulse pops the saved level back.

Software may write the priority register directly. Requests that are refused are not lost. They are sampled again at every later boundary and are taken as soon as the current priority drops below them. Level 7 is edge-sensitive. A rising edge is latched until a boundary accepts it, so a line held high at level 7 is taken only once.

All pins are plain control and status signals. The take pulse has no ready and cannot be stalled, so the consumer must act on it in the cycle it appears. There is no back-pressure anywhere on the block.

Top module: `irq_level_arbiter`

## Requirements
- R1: Bit k of `req_i` (k = 0..6) is the request for level k+1. `pending_level_o` shows the highest active level, or 0 when nothing is requested. A held level-7 line counts only until it has been accepted.
- R2: A request at level 1 to 6 is accepted only in a cycle with `boundary_i` high, and only if its level is strictly greater than `cur_prio_o`. An accepted request gives `take_o` high for exactly the one cycle after that clock edge, with `take_level_o` holding the level.
- R3: A level-7 request is accepted at the next boundary whatever the value of `cur_prio_o`, including 7.
- R4: Level 7 is taken once per rising edge of `req_i[6]`. An edge that arrives between boundaries is remembered until a boundary accepts it.
- R5: On acceptance, `cur_prio_o` becomes the accepted level in the same cycle that `take_o` is high.
- R6: A refused request stays pending and is taken at the first boundary after the priority drops below its level.
- R7: A pulse on `prio_wr_i` loads any value 0..7 from `prio_wdata_i` into `cur_prio_o` on the next clock edge.
- R8: Each acceptance pushes the previous priority onto an 8-entry save stack. A pulse on `rtn_i` pops the newest entry into `cur_prio_o`, so nested returns restore the levels in last-in, first-out order.
- R9: An acceptance with the stack full discards the value to be saved and sets the sticky flag `stack_ovf_o`, but the priority is still raised. A return with the stack empty leaves `cur_prio_o` unchanged.
- R10: When events coincide in one cycle, acceptance wins over return, and return wins over a priority write. The losing operations have no effect.
- R11: After reset, `cur_prio_o` is 7 and `take_o`, `stack_ovf_o` and the stack occupancy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Device requests; bit k is level k+1 |
| boundary_i | input | 1 | Instruction-boundary sample strobe |
| prio_wr_i | input | 1 | Software priority write strobe |
| prio_wdata_i | input | 3 | Priority value to write |
| rtn_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle accept pulse |
| take_level_o | output | 3 | Level accepted with `take_o` |
| cur_prio_o | output | 3 | Current priority level |
| pending_level_o | output | 3 | Encoded highest pending level |
| stack_ovf_o | output | 1 | Sticky save-stack overflow flag |

## Verification
The encoder is driven with sparse and mixed request patterns, which shows whether the highest line wins or some lower line leaks through. Acceptance is tried with requests below, equal to and above the current priority, which separates a strict comparison from a greater-or-equal one. It is also tried with a refused request that is held until software lowers the priority.

Level 7 is driven held high, re-pulsed and pulsed between boundaries. These patterns show apart a level-sensitive input, an input that is only sampled, and an edge that is properly latched.

Nested acceptance, coinciding strobes and a run of nine pushes followed by nine pops exercise the stack order, the precedence between strobes, and the overflow and underflow edges.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_LVL   = 7;
  localparam int LVL_W     = $clog2(NUM_LVL + 1);
  localparam int SAVE_DEPTH = 8;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int N = 7,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] lines_i,
  output logic [W-1:0] level_o
);
  // highest set line wins; later iterations overwrite lower ones
  always_comb begin
    level_o = '0;
    for (int i = 0; i < N; i++) begin
      if (lines_i[i]) level_o = W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clear_i,
  output logic pend_o
);
  logic line_q, pend_q, rise;

  assign rise   = line_i & ~line_q;
  assign pend_o = pend_q | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_i;
      pend_q <= pend_o & ~clear_i;
    end
  end

  // R4: a held line must not raise a new pending edge
  assert_no_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && line_i) |=> !pend_o);
endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;

  assign empty_o = (sp == '0);
  assign full_o  = (sp == SP_W'(DEPTH));
  assign top_o   = empty_o ? '0 : mem[IX_W'(sp - SP_W'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      if (full_o) ovf_o <= 1'b1;
      else begin
        mem[IX_W'(sp)] <= din_i;
        sp             <= sp + SP_W'(1);
      end
    end else if (pop_i && !empty_o) begin
      sp <= sp - SP_W'(1);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> (ovf_o && full_o));
  assert_sp_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int   DEPTH      = SAVE_DEPTH,
  parameter lvl_t RESET_PRIO = lvl_t'(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic             boundary_i,
  input  logic             prio_wr_i,
  input  logic [LVL_W-1:0] prio_wdata_i,
  input  logic             rtn_i,
  output logic             take_o,
  output logic [LVL_W-1:0] take_level_o,
  output logic [LVL_W-1:0] cur_prio_o,
  output logic [LVL_W-1:0] pending_level_o,
  output logic             stack_ovf_o
);
  localparam lvl_t TOP_LVL = lvl_t'(NUM_LVL);

  logic [NUM_LVL-1:0] eff_lines;
  logic               nmi_pend;
  lvl_t               lvl, saved;
  logic               accept, is_nmi, do_pop, do_wr;
  logic               stk_empty, stk_full;

  irq_edge_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .line_i(req_i[NUM_LVL-1]),
    .clear_i(accept && is_nmi), .pend_o(nmi_pend)
  );

  assign eff_lines = {nmi_pend, req_i[NUM_LVL-2:0]};

  irq_prio_encoder #(.N(NUM_LVL), .W(LVL_W)) u_enc (
    .lines_i(eff_lines), .level_o(lvl)
  );

  assign pending_level_o = lvl;
  assign is_nmi = (lvl == TOP_LVL);
  assign accept = boundary_i && (is_nmi || (lvl > cur_prio_o));
  assign do_pop = rtn_i && !accept;
  assign do_wr  = prio_wr_i && !accept && !rtn_i;

  irq_save_stack #(.DEPTH(DEPTH), .W(LVL_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(accept), .pop_i(do_pop),
    .din_i(cur_prio_o), .top_o(saved), .empty_o(stk_empty),
    .full_o(stk_full), .ovf_o(stack_ovf_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_prio_o   <= RESET_PRIO;
      take_o       <= 1'b0;
      take_level_o <= '0;
    end else begin
      take_o <= accept;
      if (accept) begin
        take_level_o <= lvl;
        cur_prio_o   <= lvl;
      end else if (do_pop) begin
        if (!stk_empty) cur_prio_o <= saved;
      end else if (do_wr) begin
        cur_prio_o <= prio_wdata_i;
      end
    end
  end

  assert_enc_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != '0) |-> eff_lines[lvl - lvl_t'(1)]);
  assert_take_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));
  assert_take_above_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_level_o != TOP_LVL) |-> (take_level_o > $past(cur_prio_o)));
  assert_nmi_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && nmi_pend) |=> (take_o && take_level_o == TOP_LVL));
  assert_prio_tracks_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cur_prio_o == take_level_o));
  assert_stack_full_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stk_full) |=> stack_ovf_o);
endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] req;
  logic       bnd, wr, rtn;
  logic [2:0] wdata;
  logic       take;
  logic [2:0] take_lvl, cur, pend;
  logic       ovf;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_level_arbiter u_irq_level_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .boundary_i(bnd),
    .prio_wr_i(wr), .prio_wdata_i(wdata), .rtn_i(rtn),
    .take_o(take), .take_level_o(take_lvl), .cur_prio_o(cur),
    .pending_level_o(pend), .stack_ovf_o(ovf)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic set_prio(int v);
    wr = 1'b1; wdata = 3'(v); tick(); wr = 1'b0;
  endtask

  task automatic strobe(bit b, bit r);
    bnd = b; rtn = r; tick(); bnd = 1'b0; rtn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 cur", cur, 7); chk("R11 take", take, 0);
    chk("R11 ovf", ovf, 0); chk("R1 none", pend, 0);
    strobe(0, 1); chk("R11 empty stack pop", cur, 7);
  endtask

  task automatic t_encode();
    req = 7'b0000101; #1 chk("R1 enc 3", pend, 3);
    req = 7'b0010010; #1 chk("R1 enc 5", pend, 5);
    req = 7'b0000001; #1 chk("R1 enc 1", pend, 1);
    req = 7'b0; #1 chk("R1 enc 0", pend, 0);
  endtask

  task automatic t_write();
    set_prio(0); chk("R7 write 0", cur, 0);
    set_prio(5); chk("R7 write 5", cur, 5);
    set_prio(0); chk("R7 write back", cur, 0);
  endtask

  task automatic t_accept();
    req = 7'b0000100; tick(); chk("R2 no boundary", take, 0);
    strobe(1, 0);
    chk("R2 take", take, 1); chk("R2 lvl", take_lvl, 3); chk("R5 raise", cur, 3);
    tick(); chk("R2 pulse", take, 0);
    req = 7'b0000110; strobe(1, 0); chk("R2 equal refused", take, 0);
    req = 7'b0; strobe(0, 1); chk("R8 return", cur, 0);
  endtask

  task automatic t_pending();
    set_prio(4); req = 7'b0000010;
    strobe(1, 0); chk("R6 refused", take, 0);
    set_prio(1); strobe(1, 0);
    chk("R6 taken late", take, 1); chk("R6 lvl", take_lvl, 2);
    req = 7'b0; strobe(0, 1); chk("R8 ret", cur, 1);
    set_prio(0);
  endtask

  task automatic t_nmi();
    set_prio(7);
    req = 7'b1000000; strobe(1, 0);
    chk("R3 nmi at prio7", take, 1); chk("R3 lvl", take_lvl, 7);
    chk("R1 held masked", pend, 0);
    strobe(1, 0); chk("R4 held once", take, 0);
    req = 7'b0; tick(); req = 7'b1000000; tick(); tick(); req = 7'b0; tick();
    strobe(1, 0); chk("R4 latched edge", take, 1);
    strobe(0, 1); chk("R8 pop7", cur, 7);
    strobe(0, 1); chk("R8 pop7b", cur, 7);
    set_prio(0);
  endtask

  task automatic t_nest();
    req = 7'b0000010; strobe(1, 0); chk("R5 nest1", cur, 2);
    req = 7'b0010010; strobe(1, 0); chk("R5 nest2", cur, 5);
    req = 7'b0;
    strobe(0, 1); chk("R8 lifo1", cur, 2);
    strobe(0, 1); chk("R8 lifo2", cur, 0);
  endtask

  task automatic t_prec();
    req = 7'b0001000; wr = 1'b1; wdata = 3'd6; strobe(1, 1); wr = 1'b0;
    chk("R10 accept wins", cur, 4); chk("R10 take", take, 1);
    req = 7'b0; wr = 1'b1; wdata = 3'd6; strobe(0, 1); wr = 1'b0;
    chk("R10 return wins", cur, 0);
  endtask

  task automatic t_ovf();
    for (int k = 0; k < 6; k++) begin
      req = 7'(1 << k); strobe(1, 0);
      chk("R9 fill", cur, k + 1);
    end
    for (int k = 0; k < 3; k++) begin
      req = 7'b1000000; strobe(1, 0); req = 7'b0; tick();
      chk("R9 flag", ovf, (k == 2) ? 1 : 0);
      chk("R3 prio7", cur, 7);
    end
    for (int k = 7; k >= 0; k--) begin
      strobe(0, 1); chk("R8 unwind", cur, k);
    end
    strobe(0, 1); chk("R9 empty pop", cur, 0);
    chk("R9 sticky", ovf, 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; bnd = 0; wr = 0; rtn = 0; wdata = '0;
    tick(); tick(); rst_n = 1'b1; tick();
    t_reset(); t_encode(); t_write(); t_accept(); t_pending();
    t_nmi(); t_nest(); t_prec(); t_ovf();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule